// File: doc/BRIEF.md
# Serial Channel Gain Register Bank

This block holds the gain settings of eight analog gain channels and is programmed over a three-wire serial link. The link has a serial clock, a data line and a load strobe. A controller shifts in an 8-bit command word, most significant bit first. It then pulses the strobe. The block decodes the captured word into an enable bit, a channel index and a 4-bit gain code, and stores the code in the selected channel's register.

The stored codes drive the analog stages directly. Code 0000 means the channel is powered down, and the block flags this on a separate output for each channel. A fixed mask output tells each stage whether it uses the coarse step size or the fine one. Only the last channel uses the coarse step by default. All channels store and decode their codes in the same way.

The strobe is sampled in the serial-clock domain. A parameter selects its polarity.

Top module: `gain_bank_top`

## Requirements
- R1: While rst_ni is low, and after it is released, every channel code is 0000, every power-save flag is 1, and the shift register is cleared.
- R2: On every rising edge of clk_i, sdata_i enters the shift register, most significant bit first. The captured word is split as follows:
  - bit 7 is the enable bit;
  - bits 6:4 are the channel index, where index k selects channel k+1;
  - bits 3:0 are the gain code.
  - Channel n occupies gain_o[4(n-1)+3 : 4(n-1)].
- R3: With LATCH_ACTIVE_LOW=0, a word executes at the first rising clk_i edge that samples latch_i low after a cycle in which it was sampled high. The word used is the eight bits shifted in before that edge; the bit sampled at that same edge is not part of it. The new code appears after that edge.
- R4: A word whose bit 7 is 0 changes no channel register when the strobe executes it.
- R5: An executed word changes only the channel it selects. The other seven codes keep their values.
- R6: If more than eight bits are shifted in before a strobe, only the last eight are used.
- R7: pwr_save_o[n-1] is 1 exactly when channel n holds code 0000.
- R8: coarse_step_o equals the COARSE_MASK parameter. Its default is 8'h80, which marks channel 8 only.
- R9: With LATCH_ACTIVE_LOW=1, execution happens on the rising edge of the strobe instead, with the same timing and the same word.
- R10: Without an execution edge on the strobe, no channel code changes, however many bits are shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock; the data line is sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sdata_i | input | 1 | Serial command data, MSB first |
| latch_i | input | 1 | Load strobe; polarity set by LATCH_ACTIVE_LOW |
| gain_o | output | NUM_CH*4 | Stored 4-bit gain codes; channel 1 in the low nibble |
| pwr_save_o | output | NUM_CH | Power-save flag per channel (code 0000) |
| coarse_step_o | output | NUM_CH | Per-channel coarse step-size indicator |

## Verification
The checker rebuilds the command word from the data line and the strobe. It then checks on every cycle that the code lands in the selected channel one cycle after the execution edge. It also checks that:
- a word with a cleared enable bit changes nothing;
- no code moves without an execution edge;
- at most one channel changes at a time;
- each power-save flag tracks its channel's code.

Other behaviours only the directed scenarios show: the reset state, that the bit sampled at the execution edge is excluded, truncation of over-long streams to their last eight bits, the fixed step-size mask, and that the active-low variant behaves the same as the active-high one.

// File: rtl/gain_bank_pkg.sv
package gain_bank_pkg;
  localparam int GAIN_W = 4;
  typedef logic [GAIN_W-1:0] gain_t;
  localparam gain_t GAIN_SLEEP = '0;

  function automatic logic is_sleep(input gain_t code);
    return code == GAIN_SLEEP;
  endfunction
endpackage

// File: rtl/gb_shift.sv
module gb_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sdata_i,
  output logic [W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_o <= '0;
    else         word_o <= {word_o[W-2:0], sdata_i};
  end
endmodule

// File: rtl/gb_strobe.sv
module gb_strobe #(
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic latch_i,
  output logic fire_o
);
  logic act, act_q;

  // normalise to active-high; execute on trailing edge of active phase
  assign act = latch_i ^ ACTIVE_LOW;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= act;
  end

  assign fire_o = act_q & ~act;
endmodule

// File: rtl/gb_chan_regs.sv
module gb_chan_regs
  import gain_bank_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int AW     = $clog2(NUM_CH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [AW-1:0]            sel_i,
  input  gain_t                    code_i,
  output logic [NUM_CH*GAIN_W-1:0] gain_o,
  output logic [NUM_CH-1:0]        sleep_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    gain_t code_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           code_q <= GAIN_SLEEP;
      else if (we_i && sel_i == AW'(c))      code_q <= code_i;
    end

    assign gain_o[c*GAIN_W +: GAIN_W] = code_q;
    assign sleep_o[c]                 = is_sleep(code_q);
  end
endmodule

// File: rtl/gain_bank_top.sv
module gain_bank_top
  import gain_bank_pkg::*;
#(
  parameter int               NUM_CH           = 8,
  parameter bit               LATCH_ACTIVE_LOW = 1'b0,
  parameter logic [NUM_CH-1:0] COARSE_MASK     = {1'b1, {(NUM_CH-1){1'b0}}}
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sdata_i,
  input  logic                     latch_i,
  output logic [NUM_CH*GAIN_W-1:0] gain_o,
  output logic [NUM_CH-1:0]        pwr_save_o,
  output logic [NUM_CH-1:0]        coarse_step_o
);
  localparam int AW     = $clog2(NUM_CH);
  localparam int WORD_W = 1 + AW + GAIN_W;

  logic [WORD_W-1:0] word;
  logic              fire;
  logic              word_en;
  logic [AW-1:0]     word_sel;
  gain_t             word_code;

  gb_shift #(.W(WORD_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sdata_i(sdata_i),
    .word_o (word)
  );

  gb_strobe #(.ACTIVE_LOW(LATCH_ACTIVE_LOW)) u_strobe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .latch_i(latch_i),
    .fire_o (fire)
  );

  assign word_en   = word[WORD_W-1];
  assign word_sel  = word[GAIN_W +: AW];
  assign word_code = word[GAIN_W-1:0];

  gb_chan_regs #(.NUM_CH(NUM_CH), .AW(AW)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (fire & word_en),
    .sel_i  (word_sel),
    .code_i (word_code),
    .gain_o (gain_o),
    .sleep_o(pwr_save_o)
  );

  assign coarse_step_o = COARSE_MASK;
endmodule

// File: rtl/gain_bank_chk.sv
module gain_bank_chk
  import gain_bank_pkg::*;
#(
  parameter int NUM_CH           = 8,
  parameter bit LATCH_ACTIVE_LOW = 1'b0
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     sdata_i,
  input logic                     latch_i,
  input logic [NUM_CH*GAIN_W-1:0] gain_o,
  input logic [NUM_CH-1:0]        pwr_save_o
);
  localparam int AW     = $clog2(NUM_CH);
  localparam int WORD_W = 1 + AW + GAIN_W;

  logic [WORD_W-1:0]        sh;
  logic                     act_q, fire;
  logic                     exp_vld;
  logic [AW-1:0]            exp_idx;
  gain_t                    exp_code;
  logic [NUM_CH*GAIN_W-1:0] prev_gain;
  logic [NUM_CH-1:0]        chg;

  assign fire = act_q & ~(latch_i ^ LATCH_ACTIVE_LOW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh        <= '0;
      act_q     <= 1'b0;
      exp_vld   <= 1'b0;
      exp_idx   <= '0;
      exp_code  <= '0;
      prev_gain <= '0;
    end else begin
      sh        <= {sh[WORD_W-2:0], sdata_i};
      act_q     <= latch_i ^ LATCH_ACTIVE_LOW;
      exp_vld   <= fire & sh[WORD_W-1];
      exp_idx   <= sh[GAIN_W +: AW];
      exp_code  <= sh[GAIN_W-1:0];
      prev_gain <= gain_o;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    assign chg[c] = prev_gain[c*GAIN_W +: GAIN_W] != gain_o[c*GAIN_W +: GAIN_W];

    assert_sleep_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pwr_save_o[c] == (gain_o[c*GAIN_W +: GAIN_W] == GAIN_SLEEP));
  end

  assert_exec_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_vld |-> gain_o[exp_idx*GAIN_W +: GAIN_W] == exp_code);

  assert_disabled_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !sh[WORD_W-1]) |=> $stable(gain_o));

  assert_single_channel_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(chg) <= 1);

  assert_no_edge_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> $stable(gain_o));
endmodule

bind gain_bank_top gain_bank_chk #(
  .NUM_CH          (NUM_CH),
  .LATCH_ACTIVE_LOW(LATCH_ACTIVE_LOW)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sdata_i   (sdata_i),
  .latch_i   (latch_i),
  .gain_o    (gain_o),
  .pwr_save_o(pwr_save_o)
);

// File: tb/gain_bank_top_tb_top.sv
`timescale 1ns/1ps
module gain_bank_top_tb_top;
  localparam int NCH = 8;
  localparam int GW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdata = 1'b0;
  logic latch = 1'b0;
  logic latch_n;

  logic [NCH*GW-1:0] gain_h, gain_l;
  logic [NCH-1:0]    ps_h, ps_l, cs_h, cs_l;

  logic [GW-1:0] exp_code [NCH];
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;
  assign latch_n = ~latch;

  gain_bank_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sdata_i(sdata), .latch_i(latch),
    .gain_o(gain_h), .pwr_save_o(ps_h), .coarse_step_o(cs_h)
  );

  gain_bank_top #(.LATCH_ACTIVE_LOW(1'b1)) dut_al_i (
    .clk_i(clk), .rst_ni(rst_n), .sdata_i(sdata), .latch_i(latch_n),
    .gain_o(gain_l), .pwr_save_o(ps_l), .coarse_step_o(cs_l)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int c = 0; c < NCH; c++) begin
      chk({req, " high-pol code"}, 32'(gain_h[c*GW +: GW]), 32'(exp_code[c]));
      chk({req, " R9 low-pol code"}, 32'(gain_l[c*GW +: GW]), 32'(exp_code[c]));
      chk({req, " R7 sleep flag"}, 32'(ps_h[c]), 32'(exp_code[c] == '0));
      chk({req, " R7 sleep flag low-pol"}, 32'(ps_l[c]), 32'(exp_code[c] == '0));
    end
  endtask

  // shift n bits MSB first, strobe active with the last bit, junk bit at exec edge
  task automatic send_bits(input logic [15:0] bits, input int n);
    logic [7:0] w;
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      sdata = bits[i];
      latch = (i == 0);
    end
    @(negedge clk);
    latch = 1'b0;
    sdata = 1'b1;
    @(negedge clk);
    sdata = 1'b0;
    w = bits[7:0];
    if (w[7]) exp_code[w[6:4]] = w[3:0];
  endtask

  task automatic t_reset();
    for (int c = 0; c < NCH; c++) exp_code[c] = '0;
    check_all("R1 reset");
    chk("R8 coarse mask", 32'(cs_h), 32'h80);
    chk("R8 coarse mask low-pol", 32'(cs_l), 32'h80);
    // strobe with cleared shift register: word 0 must not execute
    @(negedge clk); latch = 1'b1;
    @(negedge clk); latch = 1'b0;
    @(negedge clk);
    check_all("R1 cleared shift reg");
  endtask

  task automatic t_basic();
    send_bits(16'h0089, 8); check_all("R2 ch1 code 9");
    send_bits(16'h00FF, 8); check_all("R2 ch8 code F");
    send_bits(16'h00B8, 8); check_all("R3 ch4 unity");
    send_bits(16'h00D1, 8); check_all("R5 ch6 only");
  endtask

  task automatic t_ignore();
    send_bits(16'h0035, 8); check_all("R4 enable clear ch4");
    send_bits(16'h0070, 8); check_all("R4 enable clear ch8");
  endtask

  task automatic t_long();
    send_bits(16'h0F93, 12); check_all("R6 twelve bits");
    send_bits(16'h7AE6, 16); check_all("R6 sixteen bits");
  endtask

  task automatic t_sleep();
    send_bits(16'h00F0, 8); check_all("R7 ch8 to sleep");
    send_bits(16'h0080, 8); check_all("R7 ch1 to sleep");
  endtask

  task automatic t_idle();
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      sdata = 8'hC7 >> i;
    end
    repeat (4) @(negedge clk);
    sdata = 1'b0;
    check_all("R10 no strobe");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_ignore();
    t_long();
    t_sleep();
    t_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule